// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block turns the memory requests of an 8-bit microcontroller core into bus cycles on external program and data memory. The oscillator clock drives it, and one machine cycle lasts 12 clocks, numbered phase 0 to 11. Each machine cycle carries one of four kinds of work:

- idle;
- a code fetch of two bytes, at the requested address and at the address plus one;
- a data read;
- a data write.

The core offers the next request while `req_take` is high. The block latches that request on the clock edge that starts phase 0.

The block drives the following signals:

- `ale`, the address latch strobe (active high);
- `psen_n`, the code read strobe (active low);
- `rd_n` and `wr_n`, the data strobes (active low);
- a multiplexed low address/data byte, `ad_out` with output enable `ad_oe` and input `ad_in`;
- a high address byte, `a_hi`.

A mode pin is sampled during reset. With `int_rom_en` high, fetches below `IROM_SIZE` are served from internal memory; the block then raises `irom_sel` and leaves the bus quiet. The reset input takes effect only after it has stayed high for `RST_CYCLES` whole machine cycles.

Top module: `ext_bus_seq`

## Requirements
- R1: Outside reset, `ale` is high for exactly one clock in phase 0 and one clock in phase 6 of every idle or fetch cycle. That is two pulses per 12 clocks.
- R2: In a data read or write cycle, `ale` pulses only in phase 0. The phase 6 pulse is dropped.
- R3: An external fetch outputs byte address A in phases 0–1 and A+1 in phases 6–7, on `ad_out` with `ad_oe` high. `psen_n` is low in phases 2–5 and 8–11, so there are two activations per cycle.
- R4: `psen_n` stays high throughout any cycle that has no external fetch byte: idle, data read, data write, or a fetch served internally.
- R5: `a_hi` carries the fetch address high byte for an external fetch byte. For a data access with `req_wide`=1 it carries the data address high byte. For a data access with `req_wide`=0 it carries `p2_reg`.
- R6: `int_rom_en` is latched during reset. If it was latched at 1, a fetch byte whose address is below `IROM_SIZE` is internal (`irom_sel`=1, no `psen_n` activation), and a byte at or above that address is external. This is decided separately for each byte, so A and A+1 may differ. If it was latched at 0, every fetch byte is external.
- R7: Reset is recognised only after `rst_in` has been high for `RST_CYCLES`×12 consecutive clocks. A shorter pulse leaves the latched mode and the running bus unchanged.
- R8: While reset is recognised, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, and `ad_oe` is 0.
- R9: A data read drives `rd_n` low in phases 2–9, with `wr_n` high. `ad_in` is captured at the end of phase 9 and presented on `rdata`, with `rdata_vld` high during phase 10.
- R10: A data write drives `wr_n` low in phases 3–9, with `rd_n` high. `ad_out` carries `req_wdata` with `ad_oe` high in phases 2–11.
- R11: `ad_in` is captured at the end of phases 5 and 11 for each external fetch byte. The byte appears on `code_byte`, with `code_vld` high for one clock, in the following phase (6 or 0).
- R12: `req_take` is high in phase 11. The request inputs present at the end of phase 11 define the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset request, active high |
| int_rom_en | input | 1 | Mode pin, latched during reset: 1 allows internal code memory |
| req_kind | input | 2 | Next cycle: 0 idle, 1 fetch, 2 data read, 3 data write |
| req_addr | input | 16 | Fetch address or data address |
| req_wide | input | 1 | Data address is 16 bits (1) or 8 bits (0) |
| req_wdata | input | 8 | Write data |
| p2_reg | input | 8 | High port register value |
| ad_in | input | 8 | Low bus byte read from the pins |
| req_take | output | 1 | Request inputs are taken at the coming edge |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address or write data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| a_hi | output | 8 | High address port value |
| irom_sel | output | 1 | Current fetch byte comes from internal memory |
| code_byte | output | 8 | Fetched code byte |
| code_vld | output | 1 | `code_byte` valid for one clock |
| rdata | output | 8 | Data read result |
| rdata_vld | output | 1 | `rdata` valid for one clock |

## Verification
The bench fetches at 0x3FFF in internal mode, where the first byte is internal and the second is external. A design that decides the memory once per cycle would either strobe `psen_n` eight times or not at all. It also pulses `rst_in` for a single machine cycle with the mode pin flipped, and then checks that a fetch at 0x0100 still stays internal. An early reset recognition would re-latch the mode and produce code strobes. Data cycles are run with both 8-bit and 16-bit addresses, so that a mixed-up high port source shows up as a wrong `a_hi`. The `ale` and `psen_n` activations are counted across whole cycles, so a design that kept the phase 6 pulse or fired the code strobe during a data access gives the wrong count.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int IROM_SIZE  = 16384,
  parameter int RST_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_in,
  input  logic       int_rom_en,
  input  logic [1:0] req_kind,
  input  logic [15:0] req_addr,
  input  logic       req_wide,
  input  logic [7:0] req_wdata,
  input  logic [7:0] p2_reg,
  input  logic [7:0] ad_in,
  output logic       req_take,
  output logic       ale,
  output logic       psen_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  output logic [7:0] a_hi,
  output logic       irom_sel,
  output logic [7:0] code_byte,
  output logic       code_vld,
  output logic [7:0] rdata,
  output logic       rdata_vld
);
  localparam int MC_CLKS  = 12;
  localparam int RST_CLKS = RST_CYCLES * MC_CLKS;
  localparam int RW       = $clog2(RST_CLKS + 1);
  localparam logic [1:0] K_IDLE = 2'd0, K_FETCH = 2'd1, K_RD = 2'd2, K_WR = 2'd3;
  localparam logic [3:0] PH_LAST = 4'(MC_CLKS - 1);

  logic [RW-1:0] rcnt;
  logic          in_rst;
  logic [3:0]    ph, sub;
  logic [1:0]    kind;
  logic [15:0]   addr, fa;
  logic          wide, int_ok, second, fetch, data, ext_f;
  logic [7:0]    wdat;

  assign in_rst = (rcnt == RW'(RST_CLKS));

  always_ff @(posedge clk) begin
    if (!rst_in)      rcnt <= '0;
    else if (!in_rst) rcnt <= rcnt + RW'(1);
  end

  assign second = (ph >= 4'd6);
  assign sub    = second ? ph - 4'd6 : ph;
  assign fa     = second ? addr + 16'd1 : addr;
  assign fetch  = (kind == K_FETCH);
  assign data   = kind[1];
  assign ext_f  = fetch && (!int_ok || ({1'b0, fa} >= 17'(IROM_SIZE)));

  assign req_take = !in_rst && (ph == PH_LAST);
  assign ale      = !in_rst && ((ph == 4'd0) || (ph == 4'd6 && !data));
  assign psen_n   = !(!in_rst && ext_f && sub >= 4'd2);
  assign rd_n     = !(!in_rst && kind == K_RD && ph >= 4'd2 && ph <= 4'd9);
  assign wr_n     = !(!in_rst && kind == K_WR && ph >= 4'd3 && ph <= 4'd9);
  assign ad_oe    = !in_rst && ((ext_f && sub < 4'd2) || (data && ph < 4'd2) ||
                                (kind == K_WR && ph >= 4'd2));
  assign ad_out   = (kind == K_WR && ph >= 4'd2) ? wdat : (fetch ? fa[7:0] : addr[7:0]);
  assign a_hi     = ext_f ? fa[15:8] : ((data && wide) ? addr[15:8] : p2_reg);
  assign irom_sel = !in_rst && fetch && !ext_f;

  always_ff @(posedge clk) begin
    if (in_rst) begin
      ph        <= PH_LAST;
      kind      <= K_IDLE;
      addr      <= '0;
      wide      <= 1'b0;
      wdat      <= '0;
      int_ok    <= int_rom_en;
      code_byte <= '0;
      code_vld  <= 1'b0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      ph        <= (ph == PH_LAST) ? 4'd0 : ph + 4'd1;
      code_vld  <= 1'b0;
      rdata_vld <= 1'b0;
      if (ph == PH_LAST) begin
        kind <= req_kind;
        addr <= req_addr;
        wide <= req_wide;
        wdat <= req_wdata;
      end
      if (ext_f && sub == 4'd5) begin
        code_byte <= ad_in;
        code_vld  <= 1'b1;
      end
      if (kind == K_RD && ph == 4'd9) begin
        rdata     <= ad_in;
        rdata_vld <= 1'b1;
      end
    end
  end
endmodule

module ext_bus_seq_chk (
  input logic clk,
  input logic in_rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic code_vld,
  input logic rdata_vld
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (in_rst) armed <= 1'b1;

  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!armed)
    in_rst |-> (!ale && psen_n && rd_n && wr_n && !ad_oe));
  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!armed || in_rst)
    ale |=> !ale);
  assert_ale_alone_R2: assert property (@(posedge clk) disable iff (!armed || in_rst)
    ale |-> (psen_n && rd_n && wr_n));
  assert_no_code_in_data_R4: assert property (@(posedge clk) disable iff (!armed || in_rst)
    (!rd_n || !wr_n) |-> psen_n);
  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!armed || in_rst)
    !rd_n |-> wr_n);
  assert_code_after_strobe_R11: assert property (@(posedge clk) disable iff (!armed || in_rst)
    code_vld |-> $past(!psen_n));
  assert_rdata_after_strobe_R9: assert property (@(posedge clk) disable iff (!armed || in_rst)
    rdata_vld |-> $past(!rd_n));
endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
  .clk(clk), .in_rst(in_rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .code_vld(code_vld), .rdata_vld(rdata_vld)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic clk = 1'b0;
  logic rst_in = 1'b0, int_rom_en = 1'b1, req_wide = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, p2_reg = 8'h5A, ad_in = '0;
  logic req_take, ale, psen_n, rd_n, wr_n, ad_oe, irom_sel, code_vld, rdata_vld;
  logic [7:0] ad_out, a_hi, code_byte, rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  ext_bus_seq u0 (.*);

  always #5 clk = ~clk;

  int c_ale, c_psen, c_rd, c_wr;
  logic [7:0] lo0, hi0, lo6, hi6, wd4, cb6, cb0, rd10;
  logic oe0, oe6, woe4, irom0, irom6, cv6, cv0, rv10;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_mc(input logic [1:0] k, input logic [15:0] a, input logic w,
                        input logic [7:0] wd, input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk);
    while (!req_take) @(negedge clk);
    req_kind = k; req_addr = a; req_wide = w; req_wdata = wd;
    c_ale = 0; c_psen = 0; c_rd = 0; c_wr = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 0) req_kind = 2'd0;
      c_ale += int'(ale); c_psen += int'(!psen_n);
      c_rd += int'(!rd_n); c_wr += int'(!wr_n);
      if (i == 0) begin lo0 = ad_out; hi0 = a_hi; oe0 = ad_oe; irom0 = irom_sel; end
      if (i == 4) begin wd4 = ad_out; woe4 = ad_oe; end
      if (i == 5 || i == 9) ad_in = d0;
      if (i == 6) begin lo6 = ad_out; hi6 = a_hi; oe6 = ad_oe; irom6 = irom_sel;
                        cv6 = code_vld; cb6 = code_byte; end
      if (i == 10) begin rv10 = rdata_vld; rd10 = rdata; end
      if (i == 11) ad_in = d1;
    end
    @(negedge clk);
    cv0 = code_vld; cb0 = code_byte;
  endtask

  task automatic do_reset(input logic ea);
    @(negedge clk);
    rst_in = 1'b1; int_rom_en = ea;
    repeat (28) @(negedge clk);
    chk("R8 ale", ale, 0);
    chk("R8 strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk("R8 oe", ad_oe, 0);
    rst_in = 1'b0;
  endtask

  task automatic t_idle;
    run_mc(2'd0, 16'h0000, 0, 0, 0, 0);
    chk("R1 ale pulses idle", c_ale, 2);
    chk("R4 psen idle", c_psen, 0);
  endtask

  task automatic t_int_fetch;
    run_mc(2'd1, 16'h0100, 0, 0, 8'h11, 8'h22);
    chk("R6 internal psen", c_psen, 0);
    chk("R6 irom_sel", {irom0, irom6}, 2'b11);
    chk("R1 ale fetch", c_ale, 2);
    chk("R4 a_hi p2", hi0, 8'h5A);
  endtask

  task automatic t_boundary;
    run_mc(2'd1, 16'h3FFF, 0, 0, 8'h33, 8'h44);
    chk("R6 boundary psen", c_psen, 4);
    chk("R6 boundary irom", {irom0, irom6}, 2'b10);
    chk("R5 second hi", hi6, 8'h40);
    chk("R3 second lo", {oe6, lo6}, {1'b1, 8'h00});
    chk("R11 no first byte", cv6, 0);
    chk("R11 second byte", {cv0, cb0}, {1'b1, 8'h44});
  endtask

  task automatic t_ext_fetch(input logic [15:0] a);
    run_mc(2'd1, a, 0, 0, 8'hA5, 8'h5C);
    chk("R3 psen count", c_psen, 8);
    chk("R1 ale ext fetch", c_ale, 2);
    chk("R12 R3 lo0", {oe0, lo0}, {1'b1, a[7:0]});
    chk("R5 hi0", hi0, a[15:8]);
    chk("R3 lo6", lo6, 8'(a[7:0] + 8'd1));
    chk("R11 byte0", {cv6, cb6}, {1'b1, 8'hA5});
    chk("R11 byte1", {cv0, cb0}, {1'b1, 8'h5C});
  endtask

  task automatic t_short_reset;
    @(negedge clk);
    rst_in = 1'b1; int_rom_en = 1'b0;
    c_ale = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      c_ale += int'(ale);
    end
    rst_in = 1'b0;
    chk("R7 bus runs during short pulse", c_ale, 2);
    run_mc(2'd1, 16'h0100, 0, 0, 8'h00, 8'h00);
    chk("R7 mode kept psen", c_psen, 0);
    chk("R7 mode kept irom", irom0, 1);
  endtask

  task automatic t_read(input logic w, input logic [15:0] a, input logic [7:0] exp_hi);
    run_mc(2'd2, a, w, 0, 8'h9E, 8'h00);
    chk("R2 ale read", c_ale, 1);
    chk("R4 psen read", c_psen, 0);
    chk("R9 rd width", c_rd, 8);
    chk("R9 wr idle", c_wr, 0);
    chk("R5 read hi", {hi0, hi6}, {exp_hi, exp_hi});
    chk("R9 rdata", {rv10, rd10}, {1'b1, 8'h9E});
    chk("R12 read lo", {oe0, lo0}, {1'b1, a[7:0]});
  endtask

  task automatic t_write;
    run_mc(2'd3, 16'hBEEF, 1, 8'hC3, 0, 0);
    chk("R2 ale write", c_ale, 1);
    chk("R10 wr width", c_wr, 7);
    chk("R10 rd idle", c_rd, 0);
    chk("R10 wdata", {woe4, wd4}, {1'b1, 8'hC3});
    chk("R5 write hi", hi0, 8'hBE);
    chk("R4 psen write", c_psen, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset(1'b1);
    t_idle();
    t_int_fetch();
    t_boundary();
    t_ext_fetch(16'h8123);
    t_short_reset();
    do_reset(1'b0);
    t_ext_fetch(16'h0100);
    t_read(1'b1, 16'h1234, 8'h12);
    t_read(1'b0, 16'h0077, 8'h5A);
    t_write();
    t_idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule